// File: doc/BRIEF.md
# ADC Conversion Timing Sequencer

This block is the digital control sequencer of a successive-approximation analog-to-digital converter. It runs on the CPU clock and derives a slower conversion clock from it through a prescaler that can be cleared. Each conversion opens by capturing the channel and reference selection. It then emits a one-cycle sample-and-hold strobe and resolves ten result bits, most significant first. For each bit it presents a trial code to the DAC and reads back a single comparator decision. The result is written into a high and a low result register, and a sticky completion flag is raised.

A conversion can be started in three ways. Software can set the start bit, which clears itself when a single conversion ends. When trigger mode is enabled, a rising edge on an external trigger input clears the prescaler, so the delay from trigger to sample is always the same. In continuous mode the start bit stays set and each conversion is followed at once by the next. The analog comparator, the DAC and the register bus are outside the block and appear only as plain ports.

Top module: `adc_seq`

## Requirements
- R1: After reset the start bit, busy, sample strobe, completion flag and both result registers are 0.
- R2: The conversion clock ticks once every D CPU cycles, with D = 2^code for a divisor code of 1 to 7 and D = 2 for code 0. The sample strobe and the completion are spaced by whole multiples of D.
- R3: A start request taken while idle begins a conversion at the next conversion-clock tick. The sample strobe is high for exactly one CPU cycle, one tick after the conversion begins. In single mode the start bit reads 0 once the conversion completes.
- R4: Ten bits are resolved MSB first, one per tick. During the trial for bit k the DAC code holds the bits already kept, with bit k set. A bit is kept when cmp_in is 1. With a comparator that reports 1 when the trial code is not above the input, the result equals the input.
- R5: res_lo holds result bits 7..0. res_hi holds result bits 9..8 in its bits 1..0, and its upper bits are 0.
- R6: The completion flag sets 11 ticks after the sample strobe, together with the result registers. It stays set until flag_clr is 1 and stays set when a new completion arrives while it is still set.
- R7: The channel and reference selections are captured when a conversion begins. Later changes do not alter mux_lat or ref_lat until the next conversion begins.
- R8: With trigger mode on and the sequencer idle, a rising edge on trig_in clears the prescaler and requests a conversion. The sample strobe is then high in the CPU cycle that follows the (3 + 2·D)-th rising clock edge after trig_in is first seen high.
- R9: A trigger edge that arrives while a conversion is running is ignored: the conversion keeps its timing and no further conversion is started.
- R10: In continuous mode the start bit stays 1, and a new conversion begins on the tick that ends the previous one, so sample strobes are 13·D CPU cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_set | input | 1 | Write of 1 to the start bit |
| auto_en | input | 1 | Enables starts from trigger edges |
| free_run | input | 1 | Continuous conversion mode |
| trig_in | input | 1 | Asynchronous trigger source |
| presc_sel | input | 3 | Prescaler divisor code |
| mux_sel | input | 4 | Requested channel selection |
| ref_sel | input | 2 | Requested reference selection |
| flag_clr | input | 1 | Write of 1 that clears the completion flag |
| cmp_in | input | 1 | Comparator decision for the current trial code |
| start_bit | output | 1 | Start bit state |
| busy | output | 1 | A conversion is running |
| sh_pulse | output | 1 | Sample-and-hold strobe |
| dac_code | output | 10 | Trial code for the DAC |
| mux_lat | output | 4 | Channel selection captured for this conversion |
| ref_lat | output | 2 | Reference selection captured for this conversion |
| res_hi | output | 8 | Upper result register |
| res_lo | output | 8 | Lower result register |
| done_flag | output | 1 | Sticky completion flag |

## Verification
The assertions assume that cmp_in is settled in every cycle as a function of the current dac_code. They also assume that start_set and flag_clr are pulses driven between clock edges, and that the trigger input changes no faster than the synchronizer can follow. The bench models the comparator combinationally from dac_code against a held input value. It changes every control input at the falling clock edge and keeps each trigger level steady for many cycles. It starts trigger-mode conversions only while the sequencer is idle with no start pending, apart from the one directed case that raises the trigger in the middle of a conversion.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    typedef struct packed {
        logic s1;
        logic s2;
        logic s3;
    } sync_t;

    function automatic int unsigned div_shift(input int unsigned code);
        return (code == 0) ? 1 : code;
    endfunction
endpackage

// File: rtl/adc_prescaler.sv
module adc_prescaler #(
    parameter int PSEL_W = 3,
    localparam int CNT_W = (1 << PSEL_W) - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [PSEL_W-1:0] sel,
    output logic              tick
);
    typedef struct packed { logic [CNT_W-1:0] cnt; } pre_t;
    pre_t pre_d, pre_q;
    logic [CNT_W:0]   full_mask;
    logic [CNT_W-1:0] mask;

    always_comb begin
        full_mask = ((CNT_W+1)'(1) << adc_seq_pkg::div_shift(32'(sel))) - (CNT_W+1)'(1);
        mask      = full_mask[CNT_W-1:0];
        tick      = ((pre_q.cnt & mask) == mask);
        pre_d     = pre_q;
        pre_d.cnt = clr ? '0 : pre_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    // R8
    presc_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !tick);
endmodule

// File: rtl/adc_trig_sync.sv
module adc_trig_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_in,
    output logic rise
);
    adc_seq_pkg::sync_t sy_d, sy_q;

    always_comb begin
        sy_d    = sy_q;
        sy_d.s1 = trig_in;
        sy_d.s2 = sy_q.s1;
        sy_d.s3 = sy_q.s2;
        rise    = sy_q.s2 & ~sy_q.s3;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    // R8
    rise_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core #(
    parameter int RES_W = 10,
    localparam int IDX_W = $clog2(RES_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    input  logic             bit_en,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             cmp_in,
    output logic [RES_W-1:0] dac_code,
    output logic [RES_W-1:0] sar_next
);
    typedef struct packed { logic [RES_W-1:0] sar; } sar_t;
    sar_t sar_d, sar_q;
    logic [RES_W-1:0] trial;

    always_comb begin
        trial    = bit_en ? (RES_W'(1) << bit_idx) : '0;
        dac_code = sar_q.sar | trial;
        sar_next = (step && bit_en && cmp_in) ? dac_code : sar_q.sar;
        sar_d    = sar_q;
        sar_d.sar = clear ? '0 : sar_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sar_q <= '0;
        else        sar_q <= sar_d;
    end

    // R4
    sar_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && bit_en && !cmp_in && !clear) |=> (dac_code & ~trial) == $past(sar_q.sar));
endmodule

// File: rtl/adc_seq.sv
module adc_seq #(
    parameter int RES_W  = 10,
    parameter int REG_W  = 8,
    parameter int PSEL_W = 3,
    parameter int MUX_W  = 4,
    parameter int REF_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_set,
    input  logic              auto_en,
    input  logic              free_run,
    input  logic              trig_in,
    input  logic [PSEL_W-1:0] presc_sel,
    input  logic [MUX_W-1:0]  mux_sel,
    input  logic [REF_W-1:0]  ref_sel,
    input  logic              flag_clr,
    input  logic              cmp_in,
    output logic              start_bit,
    output logic              busy,
    output logic              sh_pulse,
    output logic [RES_W-1:0]  dac_code,
    output logic [MUX_W-1:0]  mux_lat,
    output logic [REF_W-1:0]  ref_lat,
    output logic [REG_W-1:0]  res_hi,
    output logic [REG_W-1:0]  res_lo,
    output logic              done_flag
);
    localparam int FIRST_CYC = 3;
    localparam int LAST_CYC  = FIRST_CYC + RES_W - 1;
    localparam int DONE_CYC  = LAST_CYC + 1;
    localparam int CYC_W     = $clog2(DONE_CYC + 1);
    localparam int IDX_W     = $clog2(RES_W);
    localparam int EXT_W     = 2 * REG_W;

    typedef struct packed {
        logic             start;
        logic [CYC_W-1:0] cyc;
        logic             sh;
        logic             flag;
        logic [MUX_W-1:0] mux;
        logic [REF_W-1:0] rf;
        logic [REG_W-1:0] hi;
        logic [REG_W-1:0] lo;
    } st_t;

    st_t st_d, st_q;
    logic             tick, trig_rise, accept_trig, begin_conv, bit_en, step;
    logic [IDX_W-1:0] bit_idx;
    logic [RES_W-1:0] sar_next;
    logic [EXT_W-1:0] res_ext;

    adc_prescaler #(.PSEL_W(PSEL_W)) u_presc (
        .clk(clk), .rst_n(rst_n), .clr(accept_trig), .sel(presc_sel), .tick(tick)
    );

    adc_trig_sync u_sync (
        .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .rise(trig_rise)
    );

    adc_sar_core #(.RES_W(RES_W)) u_sar (
        .clk(clk), .rst_n(rst_n), .clear(begin_conv), .step(step),
        .bit_en(bit_en), .bit_idx(bit_idx), .cmp_in(cmp_in),
        .dac_code(dac_code), .sar_next(sar_next)
    );

    always_comb begin
        bit_en      = (st_q.cyc >= CYC_W'(FIRST_CYC)) && (st_q.cyc <= CYC_W'(LAST_CYC));
        bit_idx     = IDX_W'(CYC_W'(LAST_CYC) - st_q.cyc);
        step        = tick && bit_en;
        accept_trig = auto_en && trig_rise && (st_q.cyc == '0) && !st_q.start;
        begin_conv  = tick && st_q.start &&
                      ((st_q.cyc == '0) || (st_q.cyc == CYC_W'(DONE_CYC)));
        res_ext     = {{(EXT_W-RES_W){1'b0}}, sar_next};

        st_d    = st_q;
        st_d.sh = tick && (st_q.cyc == CYC_W'(1));

        if (tick) begin
            if (begin_conv) begin
                st_d.cyc = CYC_W'(1);
                st_d.mux = mux_sel;
                st_d.rf  = ref_sel;
            end else if (st_q.cyc == CYC_W'(DONE_CYC)) begin
                st_d.cyc = '0;
            end else if (st_q.cyc != '0) begin
                st_d.cyc = st_q.cyc + CYC_W'(1);
            end
        end

        if (flag_clr) st_d.flag = 1'b0;

        if (tick && (st_q.cyc == CYC_W'(LAST_CYC))) begin
            st_d.hi   = res_ext[EXT_W-1:REG_W];
            st_d.lo   = res_ext[REG_W-1:0];
            st_d.flag = 1'b1;
            if (!free_run) st_d.start = 1'b0;
        end

        if (start_set || accept_trig) st_d.start = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign start_bit = st_q.start;
    assign busy      = (st_q.cyc != '0);
    assign sh_pulse  = st_q.sh;
    assign mux_lat   = st_q.mux;
    assign ref_lat   = st_q.rf;
    assign res_hi    = st_q.hi;
    assign res_lo    = st_q.lo;
    assign done_flag = st_q.flag;

    // R3
    sh_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sh_pulse |=> !sh_pulse);

    // R6
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_flag && !flag_clr) |=> done_flag);

    // R6
    flag_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_flag) |-> $past(busy));

    // R7
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> ($stable(mux_lat) && $stable(ref_lat)));

    // R10
    free_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_bit && free_run) |=> start_bit);
endmodule

// File: tb/sim_adc_seq.sv
module sim_adc_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_set = 1'b0, auto_en = 1'b0, free_run = 1'b0, trig_in = 1'b0;
    logic [2:0] presc_sel = 3'd1;
    logic [3:0] mux_sel = 4'd0;
    logic [1:0] ref_sel = 2'd0;
    logic       flag_clr = 1'b0;
    logic       cmp_in;
    logic       start_bit, busy, sh_pulse, done_flag;
    logic [9:0] dac_code;
    logic [3:0] mux_lat;
    logic [1:0] ref_lat;
    logic [7:0] res_hi, res_lo;
    logic [9:0] vin = 10'd0;
    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    assign cmp_in = (dac_code <= vin);

    adc_seq u0 (
        .clk(clk), .rst_n(rst_n), .start_set(start_set), .auto_en(auto_en),
        .free_run(free_run), .trig_in(trig_in), .presc_sel(presc_sel),
        .mux_sel(mux_sel), .ref_sel(ref_sel), .flag_clr(flag_clr), .cmp_in(cmp_in),
        .start_bit(start_bit), .busy(busy), .sh_pulse(sh_pulse), .dac_code(dac_code),
        .mux_lat(mux_lat), .ref_lat(ref_lat), .res_hi(res_hi), .res_lo(res_lo),
        .done_flag(done_flag)
    );

    function automatic int div_of(input int code);
        return (code == 0) ? 2 : (1 << code);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk) start_set = 1'b1;
        @(negedge clk) start_set = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk) flag_clr = 1'b1;
        @(negedge clk) flag_clr = 1'b0;
    endtask

    task automatic wait_sh(output int n);
        n = 0;
        while (!sh_pulse && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic wait_flag(output int n);
        n = 0;
        while (!done_flag && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
    endtask

    task automatic check_result(input string req);
        chk({res_hi[1:0], res_lo} == vin, req, int'({res_hi[1:0], res_lo}), int'(vin));
        chk(res_hi[7:2] == 6'd0, "R5 hi upper zero", int'(res_hi), int'(vin >> 8));
    endtask

    task automatic sw_conv(input int code, input logic [9:0] v);
        int n, d;
        presc_sel = 3'(code);
        vin = v;
        d = div_of(code);
        pulse_start();
        wait_sh(n);
        @(negedge clk);
        wait_flag(n);
        n = n + 1;
        chk(n == 11 * d, "R2/R3 strobe-to-flag", n, 11 * d);
        check_result("R4/R5 result");
        chk(start_bit == 1'b0, "R3 start self-clear", int'(start_bit), 0);
        clear_flag();
        chk(done_flag == 1'b0, "R6 flag cleared", int'(done_flag), 0);
        wait_idle();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int n, d, code;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // R1 reset state
        chk({start_bit, busy, sh_pulse, done_flag} == 4'd0, "R1 controls", int'({start_bit, busy, sh_pulse, done_flag}), 0);
        chk({res_hi, res_lo} == 16'd0, "R1 results", int'({res_hi, res_lo}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // directed corners: code 0 (divide by 2), extreme inputs
        sw_conv(0, 10'd0);
        sw_conv(1, 10'd1023);
        sw_conv(7, 10'h2AA);
        for (int i = 0; i < 6; i++) sw_conv(int'($urandom_range(0, 5)), 10'($urandom));

        // R6 sticky across a second completion
        sw_conv(2, 10'd5);
        vin = 10'd300;
        pulse_start();
        wait_flag(n);
        pulse_start();
        wait_sh(n);
        @(negedge clk);
        chk(done_flag == 1'b1, "R6 flag sticky", int'(done_flag), 1);
        wait_idle();
        chk(done_flag == 1'b1, "R6 set while set", int'(done_flag), 1);
        clear_flag();

        // R7 selection captured at start
        presc_sel = 3'd2;
        mux_sel = 4'd9;
        ref_sel = 2'd2;
        pulse_start();
        wait_sh(n);
        mux_sel = 4'd3;
        ref_sel = 2'd1;
        wait_flag(n);
        chk(mux_lat == 4'd9, "R7 mux held", int'(mux_lat), 9);
        chk(ref_lat == 2'd2, "R7 ref held", int'(ref_lat), 2);
        clear_flag();
        wait_idle();
        pulse_start();
        wait_sh(n);
        chk(mux_lat == 4'd3, "R7 mux next", int'(mux_lat), 3);
        chk(ref_lat == 2'd1, "R7 ref next", int'(ref_lat), 1);
        wait_flag(n);
        clear_flag();
        wait_idle();

        // R8 auto trigger fixed delay
        auto_en = 1'b1;
        for (int i = 0; i < 5; i++) begin
            code = int'($urandom_range(0, 5));
            presc_sel = 3'(code);
            d = div_of(code);
            vin = 10'($urandom);
            repeat (int'($urandom_range(1, 20))) @(negedge clk);
            trig_in = 1'b1;
            n = 0;
            while (!sh_pulse && n < 5000) begin
                @(posedge clk);
                @(negedge clk);
                n++;
            end
            chk(n == 3 + 2 * d, "R8 trigger to strobe", n, 3 + 2 * d);
            wait_flag(n);
            check_result("R8 triggered result");
            clear_flag();
            wait_idle();
            trig_in = 1'b0;
            repeat (4) @(negedge clk);
        end

        // R9 trigger during a running conversion
        presc_sel = 3'd3;
        d = div_of(3);
        vin = 10'd777;
        pulse_start();
        wait_sh(n);
        @(negedge clk);
        repeat (20) @(negedge clk);
        trig_in = 1'b1;
        wait_flag(n);
        n = n + 21;
        chk(n == 11 * d, "R9 timing unchanged", n, 11 * d);
        check_result("R9 result");
        clear_flag();
        wait_idle();
        repeat (3 * d) @(negedge clk);
        chk(busy == 1'b0 && start_bit == 1'b0, "R9 no extra conversion", int'({busy, start_bit}), 0);
        trig_in = 1'b0;
        auto_en = 1'b0;
        repeat (4) @(negedge clk);

        // R10 continuous mode
        presc_sel = 3'd1;
        d = div_of(1);
        free_run = 1'b1;
        vin = 10'd42;
        pulse_start();
        wait_sh(n);
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            wait_sh(n);
            n = n + 1;
            chk(n == 13 * d, "R10 back-to-back spacing", n, 13 * d);
            chk(start_bit == 1'b1, "R10 start stays high", int'(start_bit), 1);
        end
        check_result("R10 result");
        free_run = 1'b0;
        wait_flag(n);
        clear_flag();
        wait_flag(n);
        wait_idle();
        chk(start_bit == 1'b0, "R10 stop after leaving mode", int'(start_bit), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule